// File: doc/BRIEF.md
# Unequal Error Protection Soft-Value Store

This block holds the 7-bit log-likelihood ratios of an iterative decoder in a small single-port word array. Each value is guarded according to how much damage a bit error would do. The sign bit is kept in three copies and chosen by majority vote. The next two magnitude bits share one parity bit, and when that parity fails three repair candidates are offered. The two middle magnitude bits share a second parity bit, and when it fails they are cleared, so the value can only shrink. The two least significant bits are stored without any redundancy.

Before a word is stored, its bits are interleaved with a fixed stride permutation, and the inverse permutation is applied on read. A burst of adjacent faulty cells therefore lands on bits of different protection levels. A lighter scheme can be chosen at elaboration. It guards only the two top bits with one shared parity and leaves the rest unprotected. A fault-injection port XORs a mask into a stored word, either once or sticky (re-applied on every later write to that address).

A read returns one cycle after the address is given. The result comes with a valid strobe and three per-level event flags. An external pattern checker drives the candidate select in the same cycle as the read.

Top module: `uep_llr_store`

## Requirements
- R1: After synchronous reset, rd_valid, l1_corrected, l2_parity_err and l3_nulled are all 0.
- R2: A read accepted at clock edge k drives rd_valid high for exactly the cycle after edge k, and the flags are 0 whenever rd_valid is 0. Write and read are never requested in the same cycle.
- R3: With no injected fault, a read returns exactly the value written to that address, and all flags are 0.
- R4: In the full scheme, flipping any single one of the three stored sign copies still returns the written value, and l1_corrected is set.
- R5: In the full scheme, when the parity over value bits 5 and 4 fails, l2_parity_err is set and cand_sel picks the repair. 00 and 01 invert bit 5, 10 inverts bit 4, and 11 inverts both.
- R6: In the full scheme, a single error in value bit 3, value bit 2 or their parity returns bits 3:2 as zero, keeps all other bits, and sets l3_nulled.
- R7: In the full scheme, an error in value bit 1 or 0 appears unchanged at the output, and no flag is set.
- R8: In the full scheme, the logical word is laid out as follows: bits 1:0 are value bits 1:0, bits 3:2 are value bits 3:2, bit 4 is their parity, bit 5 is value bit 4, bit 6 is value bit 5, bit 7 is their parity, and bits 10:8 are the sign copies. Logical bit l is stored at physical position (3*l) mod 11.
- R9: Any burst of 3 adjacent physical bits (full scheme) leaves the output sign bit correct, and l1_corrected is set.
- R10: A sticky fault mask is XORed into every later write to its address. Other addresses are unaffected.
- R11: In the reduced scheme (8-bit word), the logical layout is as follows: bits 4:0 are value bits 4:0, bit 5 is value bit 5, bit 6 is value bit 6, and bit 7 is the parity of bits 6 and 5. Logical bit l is stored at (3*l) mod 8. A parity failure sets l2_parity_err, and cand_sel 00 or 01 inverts bit 6, 10 inverts bit 5, and 11 inverts both. l1_corrected and l3_nulled stay 0, and a fault in bits 4:0 passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | 7 | Soft value to store |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| cand_sel | input | 2 | Repair candidate chosen by external pattern check |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 7 | Corrected soft value |
| l1_corrected | output | 1 | Sign copies disagreed |
| l2_parity_err | output | 1 | Upper magnitude parity failed, candidate applied |
| l3_nulled | output | 1 | Middle magnitude parity failed, bits cleared |
| flt_en | input | 1 | Apply fault mask now |
| flt_stuck | input | 1 | Also keep the mask for later writes |
| flt_addr | input | AW | Fault target address |
| flt_mask | input | PW | Physical bit flip mask |

## Verification
The assertions assume that a write and a read are never requested in the same cycle. They also assume that a fault injection does not coincide with a write. The stimulus issues each request in a cycle of its own, one task call at a time, so these conditions always hold. The parity-based repair and clearing are specified for single errors. The bench therefore places exactly one flipped bit inside a parity group, except in the burst cases, where only the sign outcome is checked.

// File: rtl/uep_pkg.sv
package uep_pkg;
    localparam int VAL_W  = 7;
    localparam int LOG_W  = 11;
    localparam int SCHEME_FULL = 0;
    localparam int SCHEME_TOP2 = 1;

    typedef logic [VAL_W-1:0] llr_t;
    typedef logic [LOG_W-1:0] lword_t;

    typedef enum logic [1:0] {
        CAND_DEF  = 2'b00,
        CAND_HI   = 2'b01,
        CAND_LO   = 2'b10,
        CAND_BOTH = 2'b11
    } cand_e;

    typedef struct packed {
        llr_t value;
        logic l1_fix;
        logic l2_err;
        logic l3_null;
    } rd_res_t;

    function automatic int phys_w(input int scheme);
        return (scheme == SCHEME_FULL) ? 11 : 8;
    endfunction

    function automatic lword_t pack_full(input llr_t v);
        lword_t w;
        w        = '0;
        w[1:0]   = v[1:0];
        w[3:2]   = v[3:2];
        w[4]     = v[3] ^ v[2];
        w[5]     = v[4];
        w[6]     = v[5];
        w[7]     = v[5] ^ v[4];
        w[10:8]  = {3{v[6]}};
        return w;
    endfunction

    function automatic lword_t pack_top2(input llr_t v);
        lword_t w;
        w      = '0;
        w[4:0] = v[4:0];
        w[5]   = v[5];
        w[6]   = v[6];
        w[7]   = v[6] ^ v[5];
        return w;
    endfunction

    function automatic llr_t apply_cand(input llr_t v, input int hi, input int lo, input cand_e sel);
        llr_t r;
        r = v;
        case (sel)
            CAND_LO:   r[lo] = ~r[lo];
            CAND_BOTH: begin
                r[hi] = ~r[hi];
                r[lo] = ~r[lo];
            end
            default:   r[hi] = ~r[hi];
        endcase
        return r;
    endfunction

    function automatic rd_res_t unpack_full(input lword_t w, input cand_e sel);
        rd_res_t res;
        logic a, b, c, perr, nerr;
        a = w[8];
        b = w[9];
        c = w[10];
        res.value[6] = (a & b) | (a & c) | (b & c);
        res.l1_fix   = !((a == b) && (b == c));
        res.value[5] = w[6];
        res.value[4] = w[5];
        perr         = w[5] ^ w[6] ^ w[7];
        nerr         = w[2] ^ w[3] ^ w[4];
        res.value[3:2] = nerr ? 2'b00 : w[3:2];
        res.value[1:0] = w[1:0];
        if (perr) res.value = apply_cand(res.value, 5, 4, sel);
        res.l2_err  = perr;
        res.l3_null = nerr;
        return res;
    endfunction

    function automatic rd_res_t unpack_top2(input lword_t w, input cand_e sel);
        rd_res_t res;
        logic perr;
        res.value[4:0] = w[4:0];
        res.value[5]   = w[5];
        res.value[6]   = w[6];
        perr           = w[5] ^ w[6] ^ w[7];
        if (perr) res.value = apply_cand(res.value, 6, 5, sel);
        res.l1_fix  = 1'b0;
        res.l2_err  = perr;
        res.l3_null = 1'b0;
        return res;
    endfunction
endpackage

// File: rtl/uep_scrambler.sv
module uep_scrambler #(
    parameter int PW     = 11,
    parameter int STRIDE = 3,
    parameter bit UNDO   = 1'b0
) (
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    for (genvar l = 0; l < PW; l++) begin : g_bit
        localparam int POS = (l * STRIDE) % PW;
        if (UNDO) begin : g_undo
            assign dout[l] = din[POS];
        end else begin : g_fwd
            assign dout[POS] = din[l];
        end
    end
endmodule

// File: rtl/uep_level_decode.sv
module uep_level_decode
    import uep_pkg::*;
#(
    parameter int SCHEME = SCHEME_FULL
) (
    input  lword_t      lw,
    input  logic [1:0]  sel,
    output rd_res_t     res
);
    if (SCHEME == SCHEME_FULL) begin : g_full
        assign res = unpack_full(lw, cand_e'(sel));
    end else begin : g_top2
        assign res = unpack_top2(lw, cand_e'(sel));
    end
endmodule

// File: rtl/uep_store.sv
module uep_store #(
    parameter int PW    = 11,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_word,
    input  logic          flt_en,
    input  logic          flt_stuck,
    input  logic [AW-1:0] flt_addr,
    input  logic [PW-1:0] flt_mask
);
    logic [PW-1:0] mem [DEPTH];
    logic          stuck_vld;
    logic [AW-1:0] stuck_addr;
    logic [PW-1:0] stuck_mask;
    logic [PW-1:0] flt_cur;

    assign rd_word = mem[rd_addr];
    assign flt_cur = mem[flt_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            stuck_vld  <= 1'b0;
            stuck_addr <= '0;
            stuck_mask <= '0;
        end else begin
            if (wr_en) begin
                if (stuck_vld && (wr_addr == stuck_addr))
                    mem[wr_addr] <= wr_word ^ stuck_mask;
                else
                    mem[wr_addr] <= wr_word;
            end else if (flt_en) begin
                mem[flt_addr] <= flt_cur ^ flt_mask;
            end
            if (flt_en && flt_stuck) begin
                stuck_vld  <= 1'b1;
                stuck_addr <= flt_addr;
                stuck_mask <= flt_mask;
            end
        end
    end

    // R10: a one-shot fault lands in the addressed word
    p_fault_xor_r10: assert property (@(posedge clk) disable iff (rst)
        (flt_en && !wr_en) |=> (mem[$past(flt_addr)] == ($past(flt_cur) ^ $past(flt_mask))));

    // R10: sticky mask is re-applied on a later write
    p_stuck_rewrite_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && stuck_vld && (wr_addr == stuck_addr)) |=>
            (mem[$past(wr_addr)] == ($past(wr_word) ^ $past(stuck_mask))));
endmodule

// File: rtl/uep_llr_store.sv
module uep_llr_store
    import uep_pkg::*;
#(
    parameter int SCHEME = SCHEME_FULL,
    parameter int DEPTH  = 16,
    parameter int STRIDE = 3,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = phys_w(SCHEME)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [6:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [1:0]    cand_sel,
    output logic          rd_valid,
    output logic [6:0]    rd_data,
    output logic          l1_corrected,
    output logic          l2_parity_err,
    output logic          l3_nulled,
    input  logic          flt_en,
    input  logic          flt_stuck,
    input  logic [AW-1:0] flt_addr,
    input  logic [PW-1:0] flt_mask
);
    lword_t        log_wr;
    lword_t        log_rd_ext;
    logic [PW-1:0] phys_wr;
    logic [PW-1:0] phys_rd;
    logic [PW-1:0] log_rd;
    rd_res_t       res;

    assign log_wr = (SCHEME == SCHEME_FULL) ? pack_full(wr_data) : pack_top2(wr_data);

    uep_scrambler #(.PW(PW), .STRIDE(STRIDE), .UNDO(1'b0)) u_scr (
        .din  (log_wr[PW-1:0]),
        .dout (phys_wr)
    );

    uep_store #(.PW(PW), .DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (phys_wr),
        .rd_addr   (rd_addr),
        .rd_word   (phys_rd),
        .flt_en    (flt_en),
        .flt_stuck (flt_stuck),
        .flt_addr  (flt_addr),
        .flt_mask  (flt_mask)
    );

    uep_scrambler #(.PW(PW), .STRIDE(STRIDE), .UNDO(1'b1)) u_unscr (
        .din  (phys_rd),
        .dout (log_rd)
    );

    always_comb begin
        log_rd_ext         = '0;
        log_rd_ext[PW-1:0] = log_rd;
    end

    uep_level_decode #(.SCHEME(SCHEME)) u_dec (
        .lw  (log_rd_ext),
        .sel (cand_sel),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            l1_corrected  <= 1'b0;
            l2_parity_err <= 1'b0;
            l3_nulled     <= 1'b0;
        end else begin
            rd_valid      <= rd_en;
            l1_corrected  <= rd_en & res.l1_fix;
            l2_parity_err <= rd_en & res.l2_err;
            l3_nulled     <= rd_en & res.l3_null;
            if (rd_en) rd_data <= res.value;
        end
    end

    // R2: one-cycle read latency
    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    p_flags_with_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (l1_corrected || l2_parity_err || l3_nulled) |-> rd_valid);
    p_no_rw_clash_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));
    // R6: a cleared middle group really reads as zero
    p_l3_zeroed_r6: assert property (@(posedge clk) disable iff (rst)
        l3_nulled |-> (rd_data[3:2] == 2'b00));
    // R11: reduced scheme never raises level 1 or level 3 events
    p_top2_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (SCHEME != SCHEME_FULL) |-> (!l1_corrected && !l3_nulled));
endmodule

// File: tb/sim_uep_llr_store.sv
`timescale 1ns/1ps
module sim_uep_llr_store;
    localparam int AW  = 4;
    localparam int PWF = 11;
    localparam int PWR = 8;

    typedef struct packed {
        logic [6:0] v;
        logic       f1, f2, f3;
        logic       sign_only;
        logic [7:0] req;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    always #2.5 clk = ~clk;

    logic           wr_en = 0, rd_en = 0, flt_en = 0, flt_stuck = 0;
    logic [AW-1:0]  wr_addr = 0, rd_addr = 0, flt_addr = 0;
    logic [6:0]     wr_data = 0;
    logic [1:0]     cand_sel = 0;
    logic [PWF-1:0] flt_mask = 0;
    logic           rd_valid, l1_c, l2_e, l3_n;
    logic [6:0]     rd_data;

    logic           r_wr_en = 0, r_rd_en = 0, r_flt_en = 0;
    logic [AW-1:0]  r_wr_addr = 0, r_rd_addr = 0, r_flt_addr = 0;
    logic [6:0]     r_wr_data = 0;
    logic [1:0]     r_sel = 0;
    logic [PWR-1:0] r_flt_mask = 0;
    logic           r_valid, r_l1, r_l2, r_l3;
    logic [6:0]     r_data;

    uep_llr_store #(.SCHEME(0)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .cand_sel(cand_sel),
        .rd_valid(rd_valid), .rd_data(rd_data), .l1_corrected(l1_c),
        .l2_parity_err(l2_e), .l3_nulled(l3_n),
        .flt_en(flt_en), .flt_stuck(flt_stuck), .flt_addr(flt_addr), .flt_mask(flt_mask)
    );

    uep_llr_store #(.SCHEME(1)) u1 (
        .clk(clk), .rst(rst), .wr_en(r_wr_en), .wr_addr(r_wr_addr), .wr_data(r_wr_data),
        .rd_en(r_rd_en), .rd_addr(r_rd_addr), .cand_sel(r_sel),
        .rd_valid(r_valid), .rd_data(r_data), .l1_corrected(r_l1),
        .l2_parity_err(r_l2), .l3_nulled(r_l3),
        .flt_en(r_flt_en), .flt_stuck(1'b0), .flt_addr(r_flt_addr), .flt_mask(r_flt_mask)
    );

    int   errors = 0;
    int   total  = 0;
    bit   done   = 0;
    exp_t q[$];

    task automatic chk(input bit ok, input int req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int pf(input int l);
        return (3 * l) % PWF;
    endfunction

    function automatic int pr(input int l);
        return (3 * l) % PWR;
    endfunction

    // monitor: pop expected results as they appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (q.size() == 0) begin
                chk(0, 2, "unexpected rd_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.sign_only) begin
                    chk(rd_data[6] == e.v[6], e.req, "sign", rd_data[6], e.v[6]);
                    chk(l1_c == e.f1, e.req, "l1 flag", l1_c, e.f1);
                end else begin
                    chk(rd_data == e.v, e.req, "data", rd_data, e.v);
                    chk({l1_c, l2_e, l3_n} == {e.f1, e.f2, e.f3}, e.req, "flags",
                        {l1_c, l2_e, l3_n}, {e.f1, e.f2, e.f3});
                end
            end
        end
    end

    task automatic wr(input int a, input logic [6:0] v);
        wr_en = 1; wr_addr = AW'(a); wr_data = v;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic inj(input int a, input logic [PWF-1:0] m, input bit stuck);
        flt_en = 1; flt_stuck = stuck; flt_addr = AW'(a); flt_mask = m;
        @(posedge clk); #1;
        flt_en = 0; flt_stuck = 0; flt_mask = '0;
    endtask

    task automatic rd(input int a, input logic [1:0] s, input logic [6:0] v,
                      input logic f1, input logic f2, input logic f3,
                      input bit sign_only, input int req);
        exp_t e;
        e.v = v; e.f1 = f1; e.f2 = f2; e.f3 = f3; e.sign_only = sign_only; e.req = 8'(req);
        q.push_back(e);
        rd_en = 1; rd_addr = AW'(a); cand_sel = s;
        @(posedge clk); #1;
        rd_en = 0; cand_sel = 2'b00;
    endtask

    function automatic logic [6:0] cmask(input logic [1:0] s);
        case (s)
            2'b10:   return 7'h10;
            2'b11:   return 7'h30;
            default: return 7'h20;
        endcase
    endfunction

    function automatic logic [6:0] rmask(input logic [1:0] s);
        case (s)
            2'b10:   return 7'h20;
            2'b11:   return 7'h60;
            default: return 7'h40;
        endcase
    endfunction

    task automatic r_check(input int a, input logic [1:0] s, input logic [6:0] v, input logic f2);
        r_rd_en = 1; r_rd_addr = AW'(a); r_sel = s;
        @(posedge clk); #1;
        r_rd_en = 0;
        @(negedge clk);
        chk(r_valid == 1'b1, 11, "reduced valid", r_valid, 1);
        chk(r_data == v, 11, "reduced data", r_data, v);
        chk({r_l1, r_l2, r_l3} == {1'b0, f2, 1'b0}, 11, "reduced flags",
            {r_l1, r_l2, r_l3}, {1'b0, f2, 1'b0});
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; total++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        logic [6:0] pat [6];
        pat = '{7'h00, 7'h7F, 7'h55, 7'h2A, 7'h4C, 7'h33};
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(rd_valid == 0, 1, "rd_valid after reset", rd_valid, 0);
        chk({l1_c, l2_e, l3_n} == 3'b000, 1, "flags after reset", {l1_c, l2_e, l3_n}, 0);
        chk(r_valid == 0, 1, "reduced valid after reset", r_valid, 0);
        @(posedge clk); #1;

        // R3 clean round trips
        for (int i = 0; i < 6; i++) wr(i, pat[i]);
        for (int i = 0; i < 6; i++) rd(i, 2'b00, pat[i], 0, 0, 0, 0, 3);

        // R2 valid lasts one cycle
        rd(0, 2'b00, pat[0], 0, 0, 0, 0, 2);
        @(negedge clk); @(negedge clk);
        chk(rd_valid == 0, 2, "valid drops after one cycle", rd_valid, 0);
        chk({l1_c, l2_e, l3_n} == 3'b000, 2, "flags low without valid", {l1_c, l2_e, l3_n}, 0);
        @(posedge clk); #1;

        // R4 single error in each sign copy, both sign values
        for (int l = 8; l <= 10; l++) begin
            wr(1, 7'h4B);
            inj(1, PWF'(1) << pf(l), 0);
            rd(1, 2'b00, 7'h4B, 1, 0, 0, 0, 4);
            wr(1, 7'h0B);
            inj(1, PWF'(1) << pf(l), 0);
            rd(1, 2'b00, 7'h0B, 1, 0, 0, 0, 4);
        end

        // R5 upper magnitude parity failure, every candidate
        wr(2, 7'h30);
        inj(2, PWF'(1) << pf(6), 0);
        for (int s = 0; s < 4; s++)
            rd(2, 2'(s), (7'h30 ^ 7'h20) ^ cmask(2'(s)), 0, 1, 0, 0, 5);
        wr(2, 7'h45);
        inj(2, PWF'(1) << pf(5), 0);
        rd(2, 2'b10, 7'h45, 0, 1, 0, 0, 5);
        rd(2, 2'b01, (7'h45 ^ 7'h10) ^ 7'h20, 0, 1, 0, 0, 5);

        // R6 middle group cleared on any single error
        for (int l = 2; l <= 4; l++) begin
            wr(3, 7'h4E);
            inj(3, PWF'(1) << pf(l), 0);
            rd(3, 2'b00, 7'h42, 0, 0, 1, 0, 6);
        end

        // R7 unprotected bits pass through
        wr(4, 7'h25);
        inj(4, PWF'(1) << pf(0), 0);
        rd(4, 2'b00, 7'h24, 0, 0, 0, 0, 7);
        wr(4, 7'h25);
        inj(4, PWF'(1) << pf(1), 0);
        rd(4, 2'b00, 7'h27, 0, 0, 0, 0, 7);

        // R8 layout check: sign copy at a known physical position (logical 9 -> physical 5)
        wr(5, 7'h40);
        inj(5, PWF'(1) << 5, 0);
        rd(5, 2'b00, 7'h40, 1, 0, 0, 0, 8);

        // R9 three-bit adjacent bursts at every start position
        for (int st = 0; st <= PWF - 3; st++) begin
            logic [6:0] v;
            v = (st % 2) ? 7'h40 : 7'h3F;
            wr(6, v);
            inj(6, PWF'(3'b111) << st, 0);
            rd(6, 2'b00, v, 1, 0, 0, 1, 9);
        end

        // R10 sticky fault re-applied on each write, other address clean
        inj(7, PWF'(1) << pf(0), 1);
        wr(7, 7'h10);
        rd(7, 2'b00, 7'h11, 0, 0, 0, 0, 10);
        wr(7, 7'h11);
        rd(7, 2'b00, 7'h10, 0, 0, 0, 0, 10);
        wr(8, 7'h10);
        rd(8, 2'b00, 7'h10, 0, 0, 0, 0, 10);

        repeat (4) @(posedge clk);
        #1;
        chk(q.size() == 0, 2, "results outstanding", q.size(), 0);

        // R11 reduced scheme
        r_wr_en = 1; r_wr_addr = 0; r_wr_data = 7'h60;
        @(posedge clk); #1 r_wr_en = 0;
        r_check(0, 2'b00, 7'h60, 0);
        r_flt_en = 1; r_flt_addr = 0; r_flt_mask = PWR'(1) << pr(6);
        @(posedge clk); #1 r_flt_en = 0;
        for (int s = 0; s < 4; s++)
            r_check(0, 2'(s), (7'h60 ^ 7'h40) ^ rmask(2'(s)), 1);
        r_wr_en = 1; r_wr_addr = 1; r_wr_data = 7'h05;
        @(posedge clk); #1 r_wr_en = 0;
        r_flt_en = 1; r_flt_addr = 1; r_flt_mask = PWR'(1) << pr(3);
        @(posedge clk); #1 r_flt_en = 0;
        r_check(1, 2'b00, 7'h0D, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule